// File: doc/BRIEF.md
# Self-Arbitrating Priority Node for Shared Wired-OR ID Lines

Each device that wants a shared resource holds one copy of this node. While its request input is high, the node drives its own identifier onto a group of shared lines whose value is the bitwise OR of every node's outputs. It reads the combined value back and compares it with its own identifier, starting at the most significant bit. At the highest bit where its own identifier holds 0 but the lines show 1, the node has been outranked there, so it clears that bit and every bit below it on its output. Bits above that point stay as they are.

Every node repeats this comparison on each clock. The line value therefore converges to the largest identifier among the competitors. Once the lines have stayed the same for a set number of cycles, each node makes its decision. The one node whose identifier equals the settled line value raises its won output. No central arbiter takes part.

A node whose request is low drives zeros and never wins. Identifiers must be unique and nonzero.

Top module: `arb_node`

## Requirements
- R1: After reset, `line_drive_o` is all zeros and `won_o` is 0.
- R2: One clock after the clock edge at which `start_i` is sampled low, `line_drive_o` is zero and `won_o` is 0. A node whose `start_i` stays low never drives a 1 and never wins.
- R3: The node samples `id_i` at the first edge where `start_i` is high, and drives that value from that edge on. Later changes of `id_i` during the same request have no effect on drive or outcome.
- R4: From the second request edge onward, at each edge the drive becomes the captured ID with bit k and all lower bits cleared. Here k is the highest bit where the ID bit is 0 and the sensed line bit is 1. If no such bit exists, the full ID is driven. For example, ID 0101 sensing 0111 drives 0100.
- R5: `line_drive_o` never has a 1 in a bit position where the captured ID has a 0.
- R6: `won_o` is not raised before SETTLE (default 4) consecutive sampled line values have been equal after capture. In particular, it is 0 for the first SETTLE edges of a request.
- R7: After settling, exactly the competitor with the numerically largest ID raises `won_o`, and the lines read that ID.
- R8: Once decided, `won_o` and `line_drive_o` hold their values while `start_i` stays high.
- R9: A lone competitor wins, with the lines equal to its own ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request; high while this node competes |
| id_i | input | W | Identifier of this node, nonzero and unique |
| line_sense_i | input | W | Wired-OR value seen on the shared lines |
| line_drive_o | output | W | Bits this node asserts onto the shared lines |
| won_o | output | 1 | High when this node has won the current round |

## Verification
The hardest state to reach is a loser that has withdrawn part of its identifier, which then sees the lines change again as other competitors withdraw their own bits. That case only arises with three or more competitors whose identifiers differ at several bit positions. The bench therefore runs four nodes on a modelled OR bus, using identifier sets such as 1,2,3,15 and 3,9,10,12 that force several rounds of withdrawal. In the 0101 against 0110 case it samples the loser's drive on the second request edge, to catch the intermediate 0100 state. One round changes an identifier while the round is in progress, to show that the captured value rules.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int unsigned ARB_W_DEF      = 4;
  localparam int unsigned ARB_SETTLE_DEF = 4;

  function automatic int unsigned cnt_bits(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/arb_withdraw.sv
module arb_withdraw #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] own_id,
  input  logic [W-1:0] sensed,
  output logic [W-1:0] next_drive
);
  logic [W:0] kill;

  assign kill[W] = 1'b0;

  genvar b;
  generate
    for (b = W - 1; b >= 0; b--) begin : g_bit
      assign kill[b]       = kill[b+1] | (~own_id[b] & sensed[b]);
      assign next_drive[b] = own_id[b] & ~kill[b];
    end
  endgenerate
endmodule

// File: rtl/arb_settle.sv
module arb_settle #(
  parameter int unsigned W      = 4,
  parameter int unsigned SETTLE = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         track,
  input  logic [W-1:0] sensed,
  output logic         settled
);
  import arb_pkg::*;
  localparam int unsigned CW  = cnt_bits(SETTLE);
  localparam logic [CW-1:0] LIM = CW'(SETTLE - 1);

  logic [W-1:0]  prev_q;
  logic [CW-1:0] cnt_q;
  logic          same;

  assign same    = (sensed == prev_q);
  assign settled = track && same && (cnt_q >= LIM);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      prev_q <= '0;
      cnt_q  <= '0;
    end else if (track) begin
      prev_q <= sensed;
      if (!same)
        cnt_q <= '0;
      else if (cnt_q < LIM)
        cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/arb_node.sv
module arb_node #(
  parameter int unsigned W      = 4,
  parameter int unsigned SETTLE = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic [W-1:0] id_i,
  input  logic [W-1:0] line_sense_i,
  output logic [W-1:0] line_drive_o,
  output logic         won_o
);
  logic         active_q, done_q, won_q;
  logic [W-1:0] id_q, drive_q, drive_next;
  logic         settled;

  arb_withdraw #(.W(W)) u_withdraw (
    .own_id     (id_q),
    .sensed     (line_sense_i),
    .next_drive (drive_next)
  );

  arb_settle #(.W(W), .SETTLE(SETTLE)) u_settle (
    .clk     (clk),
    .rst     (rst),
    .clear   (~active_q),
    .track   (active_q & ~done_q),
    .sensed  (line_sense_i),
    .settled (settled)
  );

  always_ff @(posedge clk) begin
    if (rst || !start_i) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      won_q    <= 1'b0;
      id_q     <= '0;
      drive_q  <= '0;
    end else if (!active_q) begin
      active_q <= 1'b1;
      id_q     <= id_i;
      drive_q  <= id_i;
    end else if (!done_q) begin
      drive_q <= drive_next;
      if (settled) begin
        done_q <= 1'b1;
        won_q  <= (line_sense_i == id_q);
      end
    end
  end

  assign line_drive_o = drive_q;
  assign won_o        = won_q;
endmodule

// File: rtl/arb_node_chk.sv
module arb_node_chk #(
  parameter int unsigned W = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         start_i,
  input logic [W-1:0] line_sense_i,
  input logic [W-1:0] line_drive_o,
  input logic         won_o,
  input logic [W-1:0] id_q
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !start_i |=> (line_drive_o == '0) && !won_o); // R2

  AST_DRIVE_SUBSET: assert property (@(posedge clk) disable iff (rst)
    (line_drive_o & ~id_q) == '0); // R5

  AST_NO_EARLY_WIN: assert property (@(posedge clk) disable iff (rst)
    $rose(start_i) |=> !won_o); // R6

  AST_WIN_MATCHES_LINES: assert property (@(posedge clk) disable iff (rst)
    won_o |-> (line_sense_i == line_drive_o)); // R7

  AST_WIN_HELD: assert property (@(posedge clk) disable iff (rst)
    (won_o && start_i) |=> won_o); // R8

  AST_DRIVE_HELD: assert property (@(posedge clk) disable iff (rst)
    (won_o && start_i) |=> $stable(line_drive_o)); // R8
endmodule

bind arb_node arb_node_chk #(.W(W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .start_i      (start_i),
  .line_sense_i (line_sense_i),
  .line_drive_o (line_drive_o),
  .won_o        (won_o),
  .id_q         (id_q)
);

// File: tb/tb_arb_node.sv
module tb_arb_node;
  localparam int W = 4;
  localparam int N = 4;
  localparam int SETTLE = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] start = '0;
  logic [W-1:0] ids [N];
  logic [W-1:0] drv [N];
  logic [N-1:0] won;
  logic [W-1:0] lines;

  always #2 clk = ~clk;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_node
      arb_node #(.W(W), .SETTLE(SETTLE)) dut (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start[g]),
        .id_i         (ids[g]),
        .line_sense_i (lines),
        .line_drive_o (drv[g]),
        .won_o        (won[g])
      );
    end
  endgenerate

  always_comb begin
    lines = '0;
    for (int i = 0; i < N; i++) lines = lines | drv[i];
  end

  typedef struct packed {
    logic [N-1:0] won;
    logic [W-1:0] lines;
  } exp_t;

  exp_t exp_q[$];
  int n_chk = 0;
  int n_fail = 0;
  event sample_ev;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] drv_any();
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = |drv[i];
    return r;
  endfunction

  // monitor: pops expected outcome and compares at sample points
  initial begin
    forever begin
      @(sample_ev);
      if (exp_q.size() == 0) begin
        check(0, "R7 queue", 0, 1);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(won == e.won, "R7 won", int'(won), int'(e.won));
        check(lines == e.lines, "R7 lines", int'(lines), int'(e.lines));
      end
    end
  end

  // driver: computes the expected winner, pushes it, runs one round
  task automatic run_arb(input logic [N-1:0] mask, input logic [W-1:0] a,
                         input logic [W-1:0] b, input logic [W-1:0] c,
                         input logic [W-1:0] d, input bit change_id);
    exp_t e;
    int best;
    logic [W-1:0] v [N];
    v[0] = a; v[1] = b; v[2] = c; v[3] = d;
    best = -1;
    for (int i = 0; i < N; i++)
      if (mask[i] && (best < 0 || v[i] > v[best])) best = i;
    e.won = '0;
    e.lines = '0;
    if (best >= 0) begin
      e.won[best] = 1'b1;
      e.lines = v[best];
    end
    exp_q.push_back(e);
    @(negedge clk);
    for (int i = 0; i < N; i++) ids[i] = v[i];
    start = mask;
    @(negedge clk);
    if (change_id) for (int i = 0; i < N; i++) ids[i] = 4'hF; // R3: must be ignored
    @(negedge clk);
    check(won == '0, "R6 early", int'(won), 0);
    repeat (40) @(negedge clk);
    -> sample_ev;
    #0;
    repeat (3) @(negedge clk);
    check(won == e.won, "R8 held", int'(won), int'(e.won));
    for (int i = 0; i < N; i++)
      if (!mask[i]) check(drv[i] == '0, "R2 idle drive", int'(drv[i]), 0);
    start = '0;
    @(negedge clk);
    check(drv_any() == '0 && won == '0, "R2 release", int'(drv_any()), 0);
  endtask

  initial begin
    for (int i = 0; i < N; i++) ids[i] = '0;
    repeat (3) @(negedge clk);
    check(drv_any() == '0 && won == '0, "R1 reset", int'(drv_any()), 0);
    rst = 1'b0;
    @(negedge clk);

    // R4: step-by-step withdrawal for 0101 vs 0110
    ids[0] = 4'b0101; ids[1] = 4'b0110;
    start = 4'b0011;
    @(negedge clk);
    check(drv[0] == 4'b0101, "R3 capture", int'(drv[0]), 5);
    check(lines == 4'b0111, "R4 first lines", int'(lines), 7);
    @(negedge clk);
    check(drv[0] == 4'b0100, "R4 withdraw", int'(drv[0]), 4);
    check(drv[1] == 4'b0110, "R4 keep", int'(drv[1]), 6);
    check(won == '0, "R6 not yet", int'(won), 0);
    start = '0;
    @(negedge clk);

    run_arb(4'b0011, 4'd5, 4'd6, 4'd0, 4'd0, 1'b0);   // R7 example pair
    run_arb(4'b1111, 4'd1, 4'd2, 4'd3, 4'd15, 1'b0);  // R7 top ID
    run_arb(4'b1111, 4'd12, 4'd9, 4'd3, 4'd10, 1'b0); // R7 multi-round
    run_arb(4'b0011, 4'd8, 4'd7, 4'd0, 4'd0, 1'b0);   // R7 MSB decides
    run_arb(4'b0100, 4'd0, 4'd0, 4'd6, 4'd0, 1'b0);   // R9 lone node
    run_arb(4'b1010, 4'd4, 4'd9, 4'd5, 4'd11, 1'b1);  // R3 id change ignored
    run_arb(4'b0111, 4'd14, 4'd13, 4'd11, 4'd0, 1'b0);// R7 close IDs

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule